// File: doc/BRIEF.md
# Split serial-register transfer controller

This block models the serial-access side of a dual-port video memory. A storage array of `ROWS` rows, each `2*SR_W` bits wide, feeds a serial register of `SR_W` bits. That register is divided into a lower and an upper half. Transfer cycles are decoded from strobe-level controls sampled on the system clock. These controls are a row strobe, a column strobe, a transfer gate and a function select. A serial clock shifts the register out one bit at a time on `sq_out`.

A full transfer reloads the whole serial register from one half of a row and places the read pointer at any tap. A split transfer reloads only the half that is not being shifted out. The quarter of the row it copies is chosen by the block itself, so that the data lands in the idle half. The split transfer's tap is stored and takes effect when the pointer runs off the end of the active half. Output then continues without a gap while the array feeds the other half.

All strobes, `addr` and `sclk` are synchronous inputs. Their edges are detected against the value held in the previous clock cycle. Column addresses use three fields: `addr[TAP_W-1:0]` is the tap, `addr[TAP_W]` is the quarter bit, and `addr[TAP_W+1]` is the row-half select. With the defaults (`SR_W`=16, `ROWS`=16), these are bits 2:0, bit 3 and bit 4.

Top module: `split_xfer_ctrl`

## Requirements
- R1: After synchronous reset, `sq_out`, `active_hi` and `split_err` are 0, the serial register holds all zeros, and the pointer is at bit 0 of the lower half.
- R2: On a clock where `ras_n` falls, `trg_n` and `dsf` are sampled. `trg_n`=0 with `dsf`=0 selects a full transfer, and `trg_n`=0 with `dsf`=1 selects a split transfer. `trg_n`=1 selects no transfer, and the serial register and pointer are then unchanged.
- R3: A full transfer sets register bit i to bit (`addr[TAP_W+1]`*`SR_W` + i) of the latched row. It sets `active_hi` to `addr[TAP_W]` and the pointer to tap `addr[TAP_W-1:0]` within that half.
- R4: Each rising edge of `sclk` drives the register bit at the pointer onto `sq_out` and moves the pointer up by one within the active half.
- R5: When a rising `sclk` edge outputs the last bit of the active half, the other half becomes active and `active_hi` toggles. The pointer then starts at that half's stored split tap if a split load is pending there, and at bit 0 otherwise. Entering the half clears its pending status.
- R6: A split transfer writes only the inactive half h. Its bit j gets row bit (`addr[TAP_W+1]`*`SR_W` + h*`SR_W`/2 + j). The active half, `active_hi` and the pointer are left unchanged.
- R7: The quarter bit `addr[TAP_W]` has no effect on a split transfer.
- R8: A split transfer stores `addr[TAP_W-1:0]` as the start tap of the half it loaded and marks that half pending.
- R9: A split transfer before any full transfer since reset raises `split_err` for one clock and leaves the register contents unchanged.
- R10: A full transfer clears the pending status of both halves.
- R11: A split transfer may follow a full transfer directly, with no `sclk` edge in between.
- R12: The row is taken from `addr` on the `ras_n` falling clock, and the column on the first `cas_n` falling clock while `ras_n` is low. Later `cas_n` falls in the same row-strobe period and later `addr` values are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| trg_n | input | 1 | Transfer gate, active low |
| dsf | input | 1 | Function select (1 = split transfer) |
| addr | input | ADDR_W | Multiplexed row / column address |
| sclk | input | 1 | Serial clock, rising edge active |
| fill_en | input | 1 | Write one full row into the array |
| fill_row | input | ROW_W | Row written by `fill_en` |
| fill_data | input | 2*SR_W | Row contents written by `fill_en` |
| sq_out | output | 1 | Serial data output |
| active_hi | output | 1 | 1 when the upper half is being shifted out |
| split_err | output | 1 | One-cycle pulse for a split transfer without a prior full transfer |

## Verification
Every array row is filled with a distinct arithmetic pattern, so each row, row half and quarter is identifiable in the serial stream. Full transfers cover every row, with column values that visit both halves, both row halves and many taps. This separates wrong row-half selection from wrong tap placement. Split transfers sweep every tap, both row-half selects and both quarter-bit values after a full transfer. Each is followed by enough serial clocks to cross a half boundary, which shows whether the stored tap, the idle-half choice and the ignored quarter bit behave as required. Further patterns cover a split before any full transfer, cycles with the transfer gate inactive, and a second column strobe inside one row-strobe period. Each of these must leave the serial stream unchanged.

// File: rtl/svt_pkg.sv
package svt_pkg;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_FULL  = 2'd1,
        XF_SPLIT = 2'd2
    } xfer_kind_e;

    // Kind of transfer requested at the row-strobe fall.
    function automatic xfer_kind_e decode_kind(input logic trg_n, input logic dsf);
        if (trg_n) begin
            return XF_NONE;
        end
        return dsf ? XF_SPLIT : XF_FULL;
    endfunction

    // Wider of two widths.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/svt_strobe_decode.sv
module svt_strobe_decode
    import svt_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int TAP_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              trg_n,
    input  logic              dsf,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row_q,
    output logic              go,
    output xfer_kind_e        kind,
    output logic [TAP_W-1:0]  col_tap,
    output logic              col_qtr,
    output logic              col_half
);
    localparam int COL_W = TAP_W + 2;

    logic       ras_d, cas_d, cas_taken;
    logic       ras_fall, cas_fall;
    xfer_kind_e kind_q;
    logic [COL_W-1:0] col_bits;

    assign ras_fall = ras_d & ~ras_n;
    assign cas_fall = cas_d & ~cas_n & ~ras_n & ~ras_d & ~cas_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_d     <= 1'b1;
            cas_d     <= 1'b1;
            cas_taken <= 1'b0;
            kind_q    <= XF_NONE;
            row_q     <= '0;
        end else begin
            ras_d <= ras_n;
            cas_d <= cas_n;
            if (ras_fall) begin
                kind_q    <= decode_kind(trg_n, dsf);
                row_q     <= addr[ROW_W-1:0];
                cas_taken <= 1'b0;
            end else if (cas_fall) begin
                cas_taken <= 1'b1;
            end
        end
    end

    assign col_bits = addr[COL_W-1:0];
    assign col_tap  = col_bits[TAP_W-1:0];
    assign col_qtr  = col_bits[TAP_W];
    assign col_half = col_bits[TAP_W+1];
    assign go       = cas_fall && (kind_q != XF_NONE);
    assign kind     = kind_q;
endmodule

// File: rtl/svt_row_store.sv
module svt_row_store #(
    parameter int ROWS     = 16,
    parameter int ROW_BITS = 32,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                fill_en,
    input  logic [ROW_W-1:0]    fill_row,
    input  logic [ROW_BITS-1:0] fill_data,
    input  logic [ROW_W-1:0]    rd_row,
    output logic [ROW_BITS-1:0] rd_data
);
    logic [ROW_BITS-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            cells[fill_row] <= fill_data;
        end
    end

    assign rd_data = cells[rd_row];
endmodule

// File: rtl/svt_serial_unit.sv
module svt_serial_unit
    import svt_pkg::*;
#(
    parameter int SR_W     = 16,
    localparam int ROW_BITS = 2 * SR_W,
    localparam int HALF_W   = SR_W / 2,
    localparam int TAP_W    = $clog2(HALF_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  xfer_kind_e          kind,
    input  logic [TAP_W-1:0]    col_tap,
    input  logic                col_qtr,
    input  logic                col_half,
    input  logic [ROW_BITS-1:0] row_data,
    input  logic                sclk,
    output logic                sq_out,
    output logic                active_hi,
    output logic                split_err,
    output logic [SR_W-1:0]     sreg_flat,
    output logic [TAP_W-1:0]    idx_o,
    output logic [1:0]          pend_o,
    output logic                full_seen_o,
    output logic                shift_o
);
    localparam logic [TAP_W-1:0] LAST = TAP_W'(HALF_W - 1);

    logic              sclk_d, shift_edge, full_seen, cur_half;
    logic [TAP_W-1:0]  idx;
    logic              load_full, split_req, split_ok, at_last, other;
    logic [SR_W-1:0]   row_half;
    logic [HALF_W-1:0] data_w [2];
    logic [TAP_W-1:0]  tap_w  [2];
    logic [1:0]        pend_w;

    assign shift_edge = sclk & ~sclk_d;
    assign load_full  = go && (kind == XF_FULL);
    assign split_req  = go && (kind == XF_SPLIT);
    assign split_ok   = split_req && full_seen;
    assign at_last    = (idx == LAST);
    assign other      = ~cur_half;
    assign row_half   = col_half ? row_data[ROW_BITS-1:SR_W] : row_data[SR_W-1:0];

    // One storage slice per register half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] data_q;
        logic [TAP_W-1:0]  tap_q;
        logic              pend_q;
        logic              is_idle, load_here, enter_here;

        assign is_idle    = (cur_half != 1'(h));
        assign load_here  = load_full || (split_ok && is_idle);
        assign enter_here = shift_edge && at_last && is_idle;

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q <= '0;
                tap_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                if (load_here) begin
                    data_q <= row_half[h*HALF_W +: HALF_W];
                end
                if (load_full) begin
                    tap_q  <= '0;
                    pend_q <= 1'b0;
                end else if (split_ok && is_idle) begin
                    tap_q  <= col_tap;
                    pend_q <= 1'b1;
                end else if (enter_here) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign data_w[h] = data_q;
        assign tap_w[h]  = tap_q;
        assign pend_w[h] = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            full_seen <= 1'b0;
            cur_half  <= 1'b0;
            idx       <= '0;
            sq_out    <= 1'b0;
            split_err <= 1'b0;
        end else begin
            sclk_d    <= sclk;
            split_err <= split_req && !full_seen;
            if (load_full) begin
                full_seen <= 1'b1;
            end
            if (shift_edge) begin
                sq_out <= data_w[cur_half][idx];
            end
            if (load_full) begin
                cur_half <= col_qtr;
                idx      <= col_tap;
            end else if (shift_edge) begin
                if (at_last) begin
                    cur_half <= other;
                    idx      <= pend_w[other] ? tap_w[other] : '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign active_hi   = cur_half;
    assign sreg_flat   = {data_w[1], data_w[0]};
    assign idx_o       = idx;
    assign pend_o      = pend_w;
    assign full_seen_o = full_seen;
    assign shift_o     = shift_edge;
endmodule

// File: rtl/split_xfer_ctrl.sv
module split_xfer_ctrl
    import svt_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int SR_W = 16,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int ROW_BITS = 2 * SR_W,
    localparam int HALF_W   = SR_W / 2,
    localparam int TAP_W    = $clog2(HALF_W),
    localparam int COL_W    = TAP_W + 2,
    localparam int ADDR_W   = max_w(ROW_W, COL_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                trg_n,
    input  logic                dsf,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sclk,
    input  logic                fill_en,
    input  logic [ROW_W-1:0]    fill_row,
    input  logic [ROW_BITS-1:0] fill_data,
    output logic                sq_out,
    output logic                active_hi,
    output logic                split_err
);
    logic [ROW_W-1:0]    row_q;
    logic                go, col_qtr, col_half;
    xfer_kind_e          kind;
    logic [TAP_W-1:0]    col_tap;
    logic [ROW_BITS-1:0] row_data;
    logic [SR_W-1:0]     sreg_flat;
    logic [TAP_W-1:0]    idx;
    logic [1:0]          pend;
    logic                full_seen, shift_edge;

    svt_strobe_decode #(
        .ROW_W (ROW_W),
        .TAP_W (TAP_W),
        .ADDR_W(ADDR_W)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .trg_n   (trg_n),
        .dsf     (dsf),
        .addr    (addr),
        .row_q   (row_q),
        .go      (go),
        .kind    (kind),
        .col_tap (col_tap),
        .col_qtr (col_qtr),
        .col_half(col_half)
    );

    svt_row_store #(
        .ROWS    (ROWS),
        .ROW_BITS(ROW_BITS)
    ) u_store (
        .clk      (clk),
        .fill_en  (fill_en),
        .fill_row (fill_row),
        .fill_data(fill_data),
        .rd_row   (row_q),
        .rd_data  (row_data)
    );

    svt_serial_unit #(
        .SR_W(SR_W)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .kind       (kind),
        .col_tap    (col_tap),
        .col_qtr    (col_qtr),
        .col_half   (col_half),
        .row_data   (row_data),
        .sclk       (sclk),
        .sq_out     (sq_out),
        .active_hi  (active_hi),
        .split_err  (split_err),
        .sreg_flat  (sreg_flat),
        .idx_o      (idx),
        .pend_o     (pend),
        .full_seen_o(full_seen),
        .shift_o    (shift_edge)
    );
endmodule

// File: rtl/split_xfer_chk.sv
module split_xfer_chk
    import svt_pkg::*;
#(
    parameter int SR_W = 16,
    localparam int HALF_W = SR_W / 2,
    localparam int TAP_W  = $clog2(HALF_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input xfer_kind_e       kind,
    input logic             split_err,
    input logic             full_seen,
    input logic [SR_W-1:0]  sreg_flat,
    input logic [TAP_W-1:0] idx,
    input logic [1:0]       pend,
    input logic             shift_edge,
    input logic             active_hi
);
    localparam logic [TAP_W-1:0] LAST = TAP_W'(HALF_W - 1);

    logic split_acc;
    assign split_acc = go && (kind == XF_SPLIT) && full_seen;

    AST_ERR_NEEDS_NO_FULL: assert property (@(posedge clk) disable iff (rst)
        split_err |-> !$past(full_seen)); // R9

    AST_ERR_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
        split_err |-> $stable(sreg_flat)); // R9

    AST_WRAP_FLIPS_HALF: assert property (@(posedge clk) disable iff (rst)
        (shift_edge && !go && idx == LAST) |=> (active_hi != $past(active_hi))); // R5

    AST_SPLIT_KEEPS_POINTER: assert property (@(posedge clk) disable iff (rst)
        (split_acc && !shift_edge) |=> ($stable(active_hi) && $stable(idx))); // R6

    AST_SPLIT_KEEPS_ACTIVE_DATA: assert property (@(posedge clk) disable iff (rst)
        split_acc |=> ($past(active_hi) ? (sreg_flat[SR_W-1:HALF_W] == $past(sreg_flat[SR_W-1:HALF_W]))
                                        : (sreg_flat[HALF_W-1:0] == $past(sreg_flat[HALF_W-1:0])))); // R6

    AST_FULL_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (go && kind == XF_FULL) |=> (pend == 2'b00)); // R10
endmodule

bind split_xfer_ctrl split_xfer_chk #(.SR_W(SR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .kind      (kind),
    .split_err (split_err),
    .full_seen (full_seen),
    .sreg_flat (sreg_flat),
    .idx       (idx),
    .pend      (pend),
    .shift_edge(shift_edge),
    .active_hi (active_hi)
);

// File: tb/split_xfer_ctrl_test.sv
module split_xfer_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS     = 16;
    localparam int SR_W     = 16;
    localparam int ROW_W    = $clog2(ROWS);
    localparam int ROW_BITS = 2 * SR_W;
    localparam int HALF_W   = SR_W / 2;
    localparam int TAP_W    = $clog2(HALF_W);
    localparam int COL_W    = TAP_W + 2;
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, dsf = 1'b0, sclk = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic                fill_en = 1'b0;
    logic [ROW_W-1:0]    fill_row = '0;
    logic [ROW_BITS-1:0] fill_data = '0;
    logic sq_out, active_hi, split_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state
    logic [ROW_BITS-1:0] m_row [ROWS];
    logic [SR_W-1:0]     m_reg;
    logic                m_half;
    int                  m_idx;
    logic [1:0]          m_pend;
    int                  m_tap [2];
    bit                  m_full;

    split_xfer_ctrl #(.ROWS(ROWS), .SR_W(SR_W)) uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
        .dsf(dsf), .addr(addr), .sclk(sclk), .fill_en(fill_en),
        .fill_row(fill_row), .fill_data(fill_data),
        .sq_out(sq_out), .active_hi(active_hi), .split_err(split_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [ROW_BITS-1:0] pattern(input int r);
        logic [63:0] v;
        v = 64'h9E37_79B9_7F4A_7C15 * 64'(r + 1);
        v = v ^ (v >> 29);
        return v[ROW_BITS-1:0];
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // One serial clock pulse, compared against the model (R4, R5).
    task automatic shift_one(input string tag);
        logic exp_bit;
        exp_bit = m_reg[32'(m_half) * HALF_W + m_idx];
        if (m_idx == HALF_W - 1) begin
            m_half = ~m_half;
            m_idx  = m_pend[m_half] ? m_tap[m_half] : 0;
            m_pend[m_half] = 1'b0;
        end else begin
            m_idx++;
        end
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) sclk = 1'b0;
        check({tag, " R4 sq_out"}, sq_out, exp_bit);
        check({tag, " R5 active_hi"}, active_hi, m_half);
    endtask

    // One strobe cycle; a second cas fall uses a different column (R12).
    task automatic strobe_cycle(input logic trg, input logic d, input int row,
                                input logic [COL_W-1:0] col, input string tag);
        logic exp_err;
        logic [SR_W-1:0] src;
        exp_err = 1'b0;
        src = col[TAP_W+1] ? m_row[row][ROW_BITS-1:SR_W] : m_row[row][SR_W-1:0];
        @(negedge clk) begin
            ras_n = 1'b0; trg_n = trg; dsf = d; addr = ADDR_W'(row);
        end
        @(negedge clk) begin
            trg_n = 1'b1; dsf = ~d; addr = ADDR_W'(col);
        end
        @(negedge clk) cas_n = 1'b0;
        @(negedge clk) begin
            cas_n = 1'b1; addr = ~ADDR_W'(col);
        end
        if (!trg && !d) begin            // full transfer, R3 R10
            m_reg  = src;
            m_half = col[TAP_W];
            m_idx  = int'(col[TAP_W-1:0]);
            m_pend = 2'b00;
            m_tap[0] = 0;
            m_tap[1] = 0;
            m_full = 1'b1;
        end else if (!trg && d) begin
            if (!m_full) begin           // R9
                exp_err = 1'b1;
            end else begin               // R6 R7 R8
                for (int j = 0; j < HALF_W; j++) begin
                    m_reg[32'(~m_half) * HALF_W + j] = src[32'(~m_half) * HALF_W + j];
                end
                m_tap[~m_half]  = int'(col[TAP_W-1:0]);
                m_pend[~m_half] = 1'b1;
            end
        end
        check({tag, " R9 split_err"}, split_err, exp_err);
        @(negedge clk) cas_n = 1'b0;
        @(negedge clk) begin
            cas_n = 1'b1; ras_n = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_reg = '0; m_half = 1'b0; m_idx = 0; m_pend = 2'b00;
        m_tap[0] = 0; m_tap[1] = 0; m_full = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sq_out", sq_out, 1'b0);
        check("R1 active_hi", active_hi, 1'b0);
        check("R1 split_err", split_err, 1'b0);

        for (int r = 0; r < ROWS; r++) begin
            m_row[r] = pattern(r);
            @(negedge clk) begin
                fill_en = 1'b1; fill_row = ROW_W'(r); fill_data = m_row[r];
            end
        end
        @(negedge clk) fill_en = 1'b0;

        // Split before any full transfer: error, zero register kept.
        strobe_cycle(1'b0, 1'b1, 3, COL_W'(5), "R9 early split");
        for (int k = 0; k < 4; k++) shift_one("R9 after early split");

        // Full transfers over every row, several taps and halves.
        for (int r = 0; r < ROWS; r++) begin
            strobe_cycle(1'b0, 1'b0, r, COL_W'((r * 7 + 3) % (1 << COL_W)), "R3 full");
            for (int k = 0; k < HALF_W + 5; k++) shift_one("R3 R10 full read");
        end

        // Transfer gate inactive: nothing changes.
        strobe_cycle(1'b1, 1'b0, 9, COL_W'(0), "R2 no xfer");
        strobe_cycle(1'b1, 1'b1, 4, COL_W'(9), "R2 no xfer");
        for (int k = 0; k < HALF_W; k++) shift_one("R2 gate inactive");

        // Split sweep: every tap, both row halves, both quarter bits.
        strobe_cycle(1'b0, 1'b0, 5, COL_W'(0), "R11 full");
        for (int t = 0; t < HALF_W; t++) begin
            for (int a8 = 0; a8 < 2; a8++) begin
                for (int a7 = 0; a7 < 2; a7++) begin
                    strobe_cycle(1'b0, 1'b1, (t + 3 * a8 + a7) % ROWS,
                                 {1'(a8), 1'(a7), TAP_W'(t)},
                                 (a7 == 1) ? "R7 split qtr1" : "R6 R8 split");
                    for (int k = 0; k < HALF_W; k++)
                        shift_one((a7 == 1) ? "R7 R8 split read" : "R6 R8 split read");
                end
            end
        end

        // Split straight after full, then a full dropping the pending tap.
        strobe_cycle(1'b0, 1'b0, 12, {2'b11, TAP_W'(2)}, "R11 full");
        strobe_cycle(1'b0, 1'b1, 13, {2'b00, TAP_W'(5)}, "R11 split");
        for (int k = 0; k < 2 * HALF_W; k++) shift_one("R11 read");
        strobe_cycle(1'b0, 1'b1, 2, {2'b10, TAP_W'(6)}, "R8 split");
        strobe_cycle(1'b0, 1'b0, 7, {2'b01, TAP_W'(4)}, "R10 full");
        for (int k = 0; k < 2 * HALF_W + 3; k++) shift_one("R10 R12 read");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule